// File: doc/BRIEF.md
# Receive Byte FIFO with Mapped Interrupt Pins

This block buffers received payload bytes between a frame detector and a host. The frame detector hands over each completed byte with a one-cycle write strobe. The host drains the bytes in arrival order with a one-cycle read strobe, and each strobe returns one byte on a registered data port. The block keeps three status flags: not-empty, full and a sticky overflow. The default storage holds 64 bytes. A byte that arrives while the storage is full is thrown away and raises the overflow flag.

The host recovers from an overflow by writing a one to the overflow clear input. This empties the storage and clears every status flag. It also sends a one-cycle restart pulse back to the frame detector, so that the detector starts looking for a new start pattern. Two interrupt pins are each driven from a small set of FIFO events, and a 2-bit selection code per pin chooses the event. Any code that is not assigned holds the pin low.

Top module: `rx_byte_fifo_irq`

## Requirements
- R1: After reset, not_empty, full, overflow, restart_match, irq0 and irq1 are 0, and rd_data is 8'h00.
- R2: An accepted write strobe stores the byte, and not_empty reads 1 from the cycle after that strobe.
- R3: full reads 1 from the cycle after the write strobe that stores the 64th byte. It reads 0 while fewer than 64 bytes are held.
- R4: Each accepted read strobe puts the oldest stored byte on rd_data in the following cycle, so bytes come out in the order they were written.
- R5: not_empty returns to 0 in the cycle after the read that removes the last stored byte.
- R6: A write strobe while full discards the byte, leaves the stored bytes unchanged and sets overflow in the next cycle. Overflow then stays 1 until it is cleared.
- R7: A pulse on ovr_clr empties the FIFO, and in the next cycle not_empty, full and overflow all read 0. It also raises restart_match for exactly one cycle. ovr_clr takes priority over write and read strobes in the same cycle.
- R8: A read strobe while the FIFO is empty leaves rd_data, the pointers and every flag unchanged.
- R9: irq1 follows full when irq1_sel is 2'b01. For every other irq1_sel code, irq1 is 0.
- R10: irq0 follows not_empty when irq0_sel is 2'b10. When irq0_sel is 2'b01, irq0 is high for one cycle after each accepted write. For codes 2'b00 and 2'b11, irq0 is 0.
- R11: Whether a strobe is accepted depends on the state before the clock edge. With simultaneous read and write strobes: when the FIFO is full, the read is accepted and the write is dropped with overflow; when the FIFO is empty, the write is accepted and the read is ignored; otherwise both are accepted and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Byte-complete strobe from the frame detector |
| wr_data | input | 8 | Received byte |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | 8 | Registered byte returned by the last accepted read |
| ovr_clr | input | 1 | Host write of one to the overflow bit; flushes the FIFO |
| irq0_sel | input | 2 | Event selection code for irq0 |
| irq1_sel | input | 2 | Event selection code for irq1 |
| not_empty | output | 1 | At least one byte is stored |
| full | output | 1 | All 64 entries are occupied |
| overflow | output | 1 | Sticky flag: a byte was lost |
| restart_match | output | 1 | One-cycle request to restart start-pattern detection |
| irq0 | output | 1 | Mapped interrupt pin 0 |
| irq1 | output | 1 | Mapped interrupt pin 1 |

## Verification
The bench fills the FIFO to exactly 64 bytes and checks that full rises only on the last of them. A design whose count is off by one would raise full one byte early or late, or would store a 65th byte that later shows up when the FIFO is drained. The bench offers a byte to the full FIFO, with and without a read in the same cycle, and then drains every entry to confirm that the offered byte was never stored. It also pulses the overflow clear while a write strobe is present: a design that gives the clear the wrong priority keeps a stale byte and leaves not_empty set. Reads on an empty FIFO and every selection code on both pins are also exercised. These checks expose a pointer that moves on an empty read, or a reserved code that leaks an event onto a pin.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   // Selection codes for interrupt pin 0
   localparam logic [1:0] P0_WRPULSE  = 2'b01;
   localparam logic [1:0] P0_NOTEMPTY = 2'b10;
   // Selection code for interrupt pin 1
   localparam logic [1:0] P1_FULL     = 2'b01;

   // Event vector indexed by the selection code of a pin
   function automatic logic [3:0] pin_sources(input int pin,
                                               input logic ne,
                                               input logic fl,
                                               input logic wp);
      logic [3:0] v;
      v = 4'b0000;
      if (pin == 0) begin
         v[P0_WRPULSE]  = wp;
         v[P0_NOTEMPTY] = ne;
      end else begin
         v[P1_FULL]     = fl;
      end
      return v;
   endfunction

endpackage

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic          rd_stb,
   input  logic          flush,
   output logic          wr_ok,
   output logic          rd_ok,
   output logic          wr_drop,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxf_ptr_ctrl: DEPTH must be a power of two and at least 2");
   end

   logic is_full, is_empty;
   assign is_full  = (cnt == CNT_FULL);
   assign is_empty = (cnt == '0);

   // Acceptance is judged on the state before the edge
   assign wr_ok   = wr_stb && !flush && !is_full;
   assign rd_ok   = rd_stb && !flush && !is_empty;
   assign wr_drop = wr_stb && !flush && is_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R3: the write that stores the last entry makes the FIFO full
   a_r3_full_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_FULL - 1'b1) && wr_stb && !rd_stb && !flush |=> cnt == CNT_FULL);

   // R6: a dropped byte does not move the write pointer
   a_r6_drop_keeps_wptr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> $stable(wptr));

   // R11: full with both strobes only drains one entry
   a_r11_full_rw: assert property (@(posedge clk) disable iff (!rst_n)
      is_full && wr_stb && rd_stb && !flush |=> cnt == CNT_FULL - 1'b1);

   // R8: an empty read moves nothing
   a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      is_empty && rd_stb && !wr_stb && !flush |=> $stable(rptr) && cnt == '0);

   // R7: flush empties the FIFO
   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt == '0);

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ok,
   input  logic [AW-1:0] wptr,
   input  logic [DW-1:0] din,
   input  logic          rd_ok,
   input  logic [AW-1:0] rptr,
   output logic [DW-1:0] dout
);

   if (DW < 1) begin : g_bad_width
      $error("rxf_store: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dout <= '0;
      else if (rd_ok) dout <= mem[rptr];
   end

   // R8: without an accepted read the host data port holds
   a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ok |=> $stable(dout));

endmodule

// File: rtl/rxf_status.sv
module rxf_status (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ok,
   input  logic wr_drop,
   input  logic flush,
   output logic ovr,
   output logic wr_pulse,
   output logic restart
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr      <= 1'b0;
         wr_pulse <= 1'b0;
         restart  <= 1'b0;
      end else begin
         restart  <= flush;
         wr_pulse <= wr_ok;
         if (flush)        ovr <= 1'b0;
         else if (wr_drop) ovr <= 1'b1;
      end
   end

   // R6: overflow is sticky until a clear
   a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !flush |=> ovr);

   // R6: a dropped byte raises overflow
   a_r6_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> ovr);

   // R7: the restart pulse follows a clear and nothing else
   a_r7_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restart) |-> $past(flush));

endmodule

// File: rtl/rxf_irq_map.sv
module rxf_irq_map (
   input  logic [3:0] src,
   input  logic [1:0] sel,
   output logic       irq
);

   always_comb irq = src[sel];

endmodule

// File: rtl/rx_byte_fifo_irq.sv
module rx_byte_fifo_irq #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   parameter int NPINS = 2,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_stb,
   output logic [DW-1:0] rd_data,
   input  logic          ovr_clr,
   input  logic [1:0]    irq0_sel,
   input  logic [1:0]    irq1_sel,
   output logic          not_empty,
   output logic          full,
   output logic          overflow,
   output logic          restart_match,
   output logic          irq0,
   output logic          irq1
);
   import rxf_pkg::*;

   if (NPINS != 2) begin : g_bad_pins
      $error("rx_byte_fifo_irq: exactly two interrupt pins are supported");
   end

   logic          wr_ok, rd_ok, wr_drop, wr_pulse;
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;

   rxf_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .flush(ovr_clr), .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_drop(wr_drop),
      .wptr(wptr), .rptr(rptr), .cnt(cnt)
   );

   rxf_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wptr(wptr), .din(wr_data),
      .rd_ok(rd_ok), .rptr(rptr), .dout(rd_data)
   );

   rxf_status i_status (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_drop(wr_drop),
      .flush(ovr_clr), .ovr(overflow), .wr_pulse(wr_pulse),
      .restart(restart_match)
   );

   assign not_empty = (cnt != '0);
   assign full      = (cnt == CW'(DEPTH));

   logic [1:0] sel_v [NPINS];
   logic       irq_v [NPINS];
   assign sel_v[0] = irq0_sel;
   assign sel_v[1] = irq1_sel;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      rxf_irq_map i_map (
         .src(pin_sources(p, not_empty, full, wr_pulse)),
         .sel(sel_v[p]),
         .irq(irq_v[p])
      );
   end

   assign irq0 = irq_v[0];
   assign irq1 = irq_v[1];

   // R9: pin 1 carries full only under its code
   a_r9_irq1_map: assert property (@(posedge clk) disable iff (!rst_n)
      irq1 == ((irq1_sel == P1_FULL) && full));

   // R10: the write pulse on pin 0 follows an accepted byte
   a_r10_irq0_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (irq0_sel == P0_WRPULSE) && irq0 |-> $past(wr_stb));

   // R10: reserved codes keep pin 0 low
   a_r10_irq0_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (irq0_sel == 2'b00 || irq0_sel == 2'b11) |-> !irq0);

   // R2: an accepted byte makes the FIFO non-empty
   a_r2_ne_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && !full && !ovr_clr |=> not_empty);

   // R7: a clear resets all flags
   a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_clr |=> !not_empty && !full && !overflow && restart_match);

endmodule

// File: tb/test_rx_byte_fifo_irq.sv
module test_rx_byte_fifo_irq;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0, rd_stb = 1'b0, ovr_clr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] irq0_sel = 2'b00, irq1_sel = 2'b00;
   logic [7:0] rd_data;
   logic       not_empty, full, overflow, restart_match, irq0, irq1;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_byte_fifo_irq i_rx_byte_fifo_irq (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_data(rd_data), .ovr_clr(ovr_clr),
      .irq0_sel(irq0_sel), .irq1_sel(irq1_sel), .not_empty(not_empty),
      .full(full), .overflow(overflow), .restart_match(restart_match),
      .irq0(irq0), .irq1(irq1)
   );

   // Vector: {wr, rd, din[7:0], exp_rd[7:0], exp_ne}
   localparam int NV = 8;
   localparam logic [18:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'hA1, 8'h00, 1'b1},   // R2
      {1'b1, 1'b0, 8'hB2, 8'h00, 1'b1},
      {1'b0, 1'b1, 8'h00, 8'hA1, 1'b1},   // R4
      {1'b1, 1'b1, 8'hC3, 8'hB2, 1'b1},   // R11 middle
      {1'b0, 1'b1, 8'h00, 8'hC3, 1'b0},   // R5
      {1'b0, 1'b1, 8'h00, 8'hC3, 1'b0},   // R8
      {1'b1, 1'b1, 8'hD4, 8'hC3, 1'b1},   // R11 empty
      {1'b0, 1'b1, 8'h00, 8'hD4, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One clock with the given strobes; returns 1 time unit after the edge
   task automatic cyc(input logic w, input logic r, input logic c, input logic [7:0] d);
      wr_stb = w; rd_stb = r; ovr_clr = c; wr_data = d;
      @(posedge clk); #1;
      wr_stb = 1'b0; rd_stb = 1'b0; ovr_clr = 1'b0;
   endtask

   function automatic logic [7:0] fill_byte(input int i);
      return 8'(i * 3 + 1);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 3 + 1);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1
      chk("R1 not_empty", not_empty, 0);
      chk("R1 full", full, 0);
      chk("R1 overflow", overflow, 0);
      chk("R1 restart_match", restart_match, 0);
      chk("R1 irqs", {irq0, irq1}, 0);
      chk("R1 rd_data", rd_data, 8'h00);

      for (int v = 0; v < NV; v++) begin
         cyc(VEC[v][18], VEC[v][17], 1'b0, VEC[v][16:9]);
         chk("R4 vector rd_data", rd_data, VEC[v][8:1]);
         chk("R2 vector not_empty", not_empty, VEC[v][0]);
      end

      // Fill to depth
      irq1_sel = 2'b01;
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1'b1, 1'b0, 1'b0, fill_byte(i));
         if (i == DEPTH - 2) chk("R3 not full at 63", full, 0);
      end
      chk("R3 full at 64", full, 1);
      chk("R9 irq1 full code 01", irq1, 1);
      irq1_sel = 2'b00; #1; chk("R9 irq1 code 00", irq1, 0);
      irq1_sel = 2'b10; #1; chk("R9 irq1 code 10", irq1, 0);
      irq1_sel = 2'b11; #1; chk("R9 irq1 code 11", irq1, 0);
      chk("R6 no overflow yet", overflow, 0);

      // Overflow
      cyc(1'b1, 1'b0, 1'b0, 8'hEE);
      chk("R6 overflow set", overflow, 1);
      chk("R6 still full", full, 1);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R6 overflow sticky", overflow, 1);

      // Full with both strobes
      cyc(1'b1, 1'b1, 1'b0, 8'h5A);
      chk("R11 full rw read", rd_data, fill_byte(0));
      chk("R11 full rw not full", full, 0);
      chk("R11 full rw overflow", overflow, 1);

      // Drain
      for (int i = 1; i < DEPTH; i++) begin
         cyc(1'b0, 1'b1, 1'b0, 8'h00);
         chk("R4 drain order", rd_data, fill_byte(i));
         if (i == DEPTH - 2) chk("R5 not_empty before last", not_empty, 1);
      end
      chk("R5 empty after last read", not_empty, 0);
      chk("R6 overflow after drain", overflow, 1);
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
      chk("R8 empty read data", rd_data, fill_byte(DEPTH - 1));
      chk("R8 empty read flag", not_empty, 0);

      // Clear with pending bytes and a simultaneous write
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 8'h70 + 8'(i));
      chk("R2 before clear", not_empty, 1);
      cyc(1'b1, 1'b1, 1'b1, 8'h99);
      chk("R7 not_empty cleared", not_empty, 0);
      chk("R7 overflow cleared", overflow, 0);
      chk("R7 full cleared", full, 0);
      chk("R7 restart high", restart_match, 1);
      chk("R7 read blocked by clear", rd_data, fill_byte(DEPTH - 1));
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R7 restart one cycle", restart_match, 0);
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
      chk("R7 flushed read ignored", rd_data, fill_byte(DEPTH - 1));

      // irq0 mapping
      irq0_sel = 2'b10;
      cyc(1'b1, 1'b0, 1'b0, 8'h42);
      chk("R10 irq0 not_empty", irq0, 1);
      irq0_sel = 2'b00; #1; chk("R10 irq0 code 00", irq0, 0);
      irq0_sel = 2'b11; #1; chk("R10 irq0 code 11", irq0, 0);
      irq0_sel = 2'b01;
      cyc(1'b1, 1'b0, 1'b0, 8'h43);
      chk("R10 irq0 write pulse", irq0, 1);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R10 irq0 pulse ends", irq0, 0);
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
      chk("R4 after remap", rd_data, 8'h42);
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
      chk("R4 after remap 2", rd_data, 8'h43);
      irq0_sel = 2'b10; #1;
      chk("R10 irq0 empty", irq0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule